// File: doc/BRIEF.md
# Touch Pressure Calculator

This block turns one resistive-panel touch sample into a 12-bit touch resistance value. A sample is the chosen X coordinate and the two cross-plate readings Z1 and Z2, each the low 12 bits of a converter word. The board-level X-plate resistance is supplied as a 16-bit input. The block computes `((z2 - z1) * x * rplate) / z1`, rounds the quotient by adding 2047 and dropping the low 12 bits, and reports the result only when it is meaningful.

A one-cycle start strobe captures all operands, including the pen-down state, while the block is idle. Samples that cannot produce a valid value finish at once. This covers pen up, either Z reading zero, and Z2 below Z1. Every other sample goes through two multiply stages and a one-bit-per-cycle restoring divider. A result above the 12-bit maximum is dropped. Every request ends in a single-cycle done pulse, and the valid flag tells the consumer whether the pressure value is to be reported.

Top module: `touch_pressure_calc`

## Requirements
- R1: For an accepted request, pressure_o equals floor((floor((z2-z1)*x*rplate / z1) + 2047) / 4096). For example, a quotient of 2048 gives 0 and a quotient of 2049 gives 1.
- R2: A request with pen_down_i low finishes with done_o high, valid_o low and pressure_o equal to 0.
- R3: A request with z1_i equal to 0 or z2_i equal to 0 is rejected: done_o is high, valid_o is low and pressure_o is 0.
- R4: A request with z2_i below z1_i is rejected rather than wrapped: valid_o is low and pressure_o is 0.
- R5: A rounded result of 4095 is reported with valid_o high. A rounded result of 4096 or more is rejected with valid_o low and pressure_o 0. This holds for the largest operands as well.
- R6: When z2_i equals z1_i, and both are nonzero with the pen down, the request is reported with valid_o high and pressure_o 0.
- R7: done_o is high for exactly one cycle per request, and valid_o is never high without done_o.
- R8: A start_i pulse that arrives while a computation is in progress is ignored. Only the first request completes, and no further done pulse appears.
- R9: For a rejected request, done_o is high in the cycle right after the clock edge that samples start_i. For an accepted request, it is high PW+3 cycles later than that, where PW = 2*DW+RW = 40 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| pen_down_i | input | 1 | Pen-down state for this sample |
| x_i | input | 12 | Chosen X coordinate |
| z1_i | input | 12 | First cross-plate reading |
| z2_i | input | 12 | Second cross-plate reading |
| rplate_i | input | 16 | X-plate resistance |
| pressure_o | output | 12 | Rounded touch resistance, 0 when not reported |
| valid_o | output | 1 | Result is to be reported (only with done_o) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are the exact edges of the arithmetic: the rounding half point and the 4095/4096 range limit. A random sample almost never produces those exact quotients. The stimulus sets z1 to 1 and z2 to 2, so the quotient reduces to x times rplate. Choosing those two factors then places the quotient exactly on 2048, 2049, 4095·4096 and 16777215. A second start during the divide is driven mid-computation with operands that would reject, so the bench can tell whether that start was taken.

// File: rtl/touch_pressure_calc.sv
module touch_pressure_calc #(
  parameter int DW  = 12,
  parameter int RW  = 16,
  parameter int RSH = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pen_down_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] z1_i,
  input  logic [DW-1:0] z2_i,
  input  logic [RW-1:0] rplate_i,
  output logic [DW-1:0] pressure_o,
  output logic          valid_o,
  output logic          done_o
);
  localparam int PW   = 2*DW + RW;
  localparam int CW   = $clog2(PW);
  localparam int RND  = (1 << (RSH-1)) - 1;
  localparam int MAXV = (1 << DW) - 1;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_SCALE, S_DIV, S_FIN} st_t;
  st_t st;

  logic [DW-1:0]   x_r, z1_r, d_r, rem;
  logic [RW-1:0]   r_r;
  logic [2*DW-1:0] m1_r;
  logic [PW-1:0]   dvd;
  logic [CW-1:0]   cnt;

  wire reject = !pen_down_i || (z1_i == '0) || (z2_i == '0) || (z2_i < z1_i);

  wire [2*DW-1:0] m1     = (2*DW)'(d_r) * (2*DW)'(x_r);
  wire [PW-1:0]   m2     = PW'(m1_r) * PW'(r_r);
  wire [DW:0]     rem_sh = {rem, dvd[PW-1]};
  wire            ge     = rem_sh >= {1'b0, z1_r};
  wire [DW:0]     rem_n  = ge ? rem_sh - {1'b0, z1_r} : rem_sh;
  wire [PW:0]     rnd    = {1'b0, dvd} + (PW+1)'(RND);
  wire [PW:0]     zq     = rnd >> RSH;
  wire            in_rng = zq <= (PW+1)'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      x_r <= '0; z1_r <= '0; d_r <= '0; rem <= '0;
      r_r <= '0; m1_r <= '0; dvd <= '0; cnt <= '0;
      pressure_o <= '0; valid_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          if (reject) begin
            done_o     <= 1'b1;
            pressure_o <= '0;
          end else begin
            x_r  <= x_i;
            z1_r <= z1_i;
            d_r  <= z2_i - z1_i;
            r_r  <= rplate_i;
            st   <= S_MUL;
          end
        end
        S_MUL: begin
          m1_r <= m1;
          st   <= S_SCALE;
        end
        S_SCALE: begin
          dvd <= m2;
          rem <= '0;
          cnt <= '0;
          st  <= S_DIV;
        end
        S_DIV: begin
          rem <= rem_n[DW-1:0];
          dvd <= {dvd[PW-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PW-1)) st <= S_FIN;
        end
        S_FIN: begin
          done_o     <= 1'b1;
          valid_o    <= in_rng;
          pressure_o <= in_rng ? zq[DW-1:0] : '0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  rem_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV) |-> (rem_n[DW] == 1'b0));

  // R2
  pen_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st == S_IDLE && !pen_down_i) |=> (done_o && !valid_o));

  // R3
  zero_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st == S_IDLE && (z1_i == '0 || z2_i == '0)) |=> (done_o && !valid_o));

  // R4
  neg_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st == S_IDLE && z2_i < z1_i) |=> (done_o && !valid_o));

  // R2
  rej_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !valid_o) |-> (pressure_o == '0));

  // R7
  valid_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> done_o);

  // R7
  fin_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN) |=> done_o);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MUL || st == S_SCALE || st == S_DIV) |=> !done_o);
endmodule

// File: tb/test_touch_pressure_calc.sv
module test_touch_pressure_calc;
  localparam int PW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        pen_down_i = 1'b0;
  logic [11:0] x_i = '0, z1_i = '0, z2_i = '0;
  logic [15:0] rplate_i = '0;
  logic [11:0] pressure_o;
  logic        valid_o, done_o;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  touch_pressure_calc i_touch_pressure_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pen_down_i(pen_down_i),
    .x_i(x_i), .z1_i(z1_i), .z2_i(z2_i), .rplate_i(rplate_i),
    .pressure_o(pressure_o), .valid_o(valid_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input bit pen, input int x, input int z1, input int z2,
                       input int r, output bit ev, output longint ep);
    longint q;
    ev = 1'b0;
    ep = 0;
    if (pen && z1 != 0 && z2 != 0 && z2 >= z1) begin
      q = (longint'(z2 - z1) * x * r) / z1;
      q = (q + 2047) >> 12;
      if (q <= 4095) begin
        ev = 1'b1;
        ep = q;
      end
    end
  endtask

  task automatic run(input bit pen, input int x, input int z1, input int z2,
                     input int r, output int p, output bit v, output int lat);
    @(negedge clk);
    pen_down_i = pen; x_i = x[11:0]; z1_i = z1[11:0]; z2_i = z2[11:0];
    rplate_i = r[15:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    p = int'(pressure_o);
    v = valid_o;
  endtask

  task automatic case_chk(input string req, input bit pen, input int x,
                          input int z1, input int z2, input int r);
    int p, lat; bit v, ev; longint ep;
    model(pen, x, z1, z2, r, ev, ep);
    run(pen, x, z1, z2, r, p, v, lat);
    chk(v == ev, req, "valid", v, ev);
    chk(p == ep, req, "pressure", p, ep);
    chk(lat == (ev || (pen && z1 != 0 && z2 >= z1 && z2 != 0) ? PW + 4 : 1),
        "R9", "latency", lat, (ev || (pen && z1 != 0 && z2 >= z1 && z2 != 0)) ? PW + 4 : 1);
  endtask

  task automatic t_reset;
    chk(done_o == 1'b0, "R7", "reset done", done_o, 0);
    chk(valid_o == 1'b0, "R7", "reset valid", valid_o, 0);
    chk(pressure_o == '0, "R2", "reset pressure", pressure_o, 0);
  endtask

  task automatic t_basic;
    case_chk("R1", 1, 2000, 1000, 1500, 600);
    case_chk("R1", 1, 3000, 500, 3500, 450);
    case_chk("R1", 1, 77, 4000, 4095, 65535);
  endtask

  task automatic t_round;
    int p, lat; bit v;
    run(1, 1, 1, 2, 2048, p, v, lat);
    chk(v && p == 0, "R1", "half point 2048", p, 0);
    run(1, 1, 1, 2, 2049, p, v, lat);
    chk(v && p == 1, "R1", "above half 2049", p, 1);
  endtask

  task automatic t_pen;
    case_chk("R2", 0, 2000, 1000, 1500, 600);
  endtask

  task automatic t_zero;
    case_chk("R3", 1, 2000, 0, 1500, 600);
    case_chk("R3", 1, 2000, 1000, 0, 600);
  endtask

  task automatic t_neg;
    case_chk("R4", 1, 2000, 1500, 1000, 600);
  endtask

  task automatic t_range;
    int p, lat; bit v;
    run(1, 4095, 1, 2, 4096, p, v, lat);
    chk(v == 1'b1, "R5", "4095 valid", v, 1);
    chk(p == 4095, "R5", "4095 value", p, 4095);
    run(1, 4095, 1, 2, 4097, p, v, lat);
    chk(v == 1'b0, "R5", "4096 valid", v, 0);
    chk(p == 0, "R5", "4096 value", p, 0);
    case_chk("R5", 1, 4095, 1, 4095, 65535);
  endtask

  task automatic t_equal;
    int p, lat; bit v;
    run(1, 3000, 1234, 1234, 900, p, v, lat);
    chk(v == 1'b1, "R6", "equal valid", v, 1);
    chk(p == 0, "R6", "equal value", p, 0);
  endtask

  task automatic t_pulse;
    int p, lat; bit v;
    run(1, 2000, 1000, 1500, 600, p, v, lat);
    chk(done_o == 1'b1, "R7", "done seen", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
    chk(valid_o == 1'b0, "R7", "valid drops with done", valid_o, 0);
  endtask

  task automatic t_busy;
    int p, lat, extra; bit v, ev; longint ep;
    model(1, 2500, 800, 2000, 1000, ev, ep);
    @(negedge clk);
    pen_down_i = 1; x_i = 2500; z1_i = 800; z2_i = 2000; rplate_i = 1000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (10) begin
      @(negedge clk);
      lat++;
    end
    pen_down_i = 0; x_i = 5; z1_i = 0; z2_i = 0; rplate_i = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat++;
    while (!done_o && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == PW + 4, "R8", "first request latency", lat, PW + 4);
    chk(valid_o == ev, "R8", "first request valid", valid_o, ev);
    chk(int'(pressure_o) == ep, "R8", "first request value", pressure_o, ep);
    extra = 0;
    repeat (60) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk(extra == 0, "R8", "no second done", extra, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_round();
    t_pen();
    t_zero();
    t_neg();
    t_range();
    t_equal();
    t_pulse();
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule